// File: doc/BRIEF.md
# DRAM Bank Timing Legality Tracker

This block follows one DRAM rank's commands as they are issued. For every bank it keeps an open or closed state and a small set of down-counters. From these it reports, each cycle, which commands may legally go to which bank. A command scheduler built around the block reads these flags before it issues a command. The scheduler then reports the command it actually issued through a single strobe: a command code and a bank index. If the reported command breaks a timing rule or a state rule, the block raises a one-cycle error and ignores that command.

The timing values come from configuration inputs and are counted in clock cycles. A command at edge t that imposes a spacing N permits the dependent command at edge t+N. A value of 0 or 1 allows the dependent command at the next edge. The read-to-precharge spacing and the write-to-read spacing are never taken below 4. A separate registered flag marks a configuration whose row-active time is too short to cover column latency, row-to-column delay and read-to-precharge spacing together.

Top module: `dbt_tracker`

## Requirements
- R1: An ACT is legal only on a closed bank, only once tRP cycles have passed since that bank's last PRE, and only when no refresh is running. A legal ACT opens the bank. An ACT to an open bank is illegal.
- R2: A read or a write is legal only on an open bank, and only once tRCD cycles have passed since that bank's ACT. `may_rw_o[b]` shows this.
- R3: A PRE is legal only on an open bank, and only when three spacings have all elapsed: tRAS since its ACT, the effective tRTP since its last read, and tWR since its last write. `may_pre_o[b]` shows this.
- R4: The effective tRTP and the effective tWTR are each the programmed value or 4, whichever is larger.
- R5: After a legal write to any bank, no read anywhere in the rank is legal for the effective tWTR cycles. `rank_rd_ok_o` shows this, and a read is legal only when both `may_rw_o[b]` and `rank_rd_ok_o` are high.
- R6: A REF is legal only when every bank is closed and every bank's tRP has elapsed. After a legal REF, no command of any kind is legal for tRFC cycles.
- R7: An illegal command raises `err_o` for exactly one cycle, in the cycle after the command edge. An illegal command changes no bank or rank state. The same holds for a bank index of NUM_BANKS or higher.
- R8: `cfg_bad_o` is a registered flag, visible one cycle after a configuration change. It is high exactly when tRAS < tCL + tRCD + effective tRTP.
- R9: A synchronous active-high reset closes all banks and clears all counters. After reset, `may_act_o` is all ones, `may_ref_o` and `rank_rd_ok_o` are 1, and `may_rw_o`, `may_pre_o`, `err_o` and `cfg_bad_o` are all 0.
- R10: The command codes on `cmd_i` are: 0 no-op, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF. Codes 6 and 7 act as no-ops and never raise `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Issued command code (R10) |
| bank_i | input | BANK_W | Target bank of the command |
| cfg_tcl | input | TW | Column latency in cycles |
| cfg_trcd | input | TW | ACT to read/write spacing |
| cfg_tras | input | TW | ACT to PRE spacing |
| cfg_trp | input | TW | PRE to ACT spacing |
| cfg_trtp | input | TW | Read to PRE spacing (floor 4) |
| cfg_twr | input | TW | Write to PRE spacing |
| cfg_twtr | input | TW | Write to read spacing (floor 4) |
| cfg_trfc | input | RFC_W | REF to any-command spacing |
| may_act_o | output | NUM_BANKS | Per bank: ACT is legal |
| may_rw_o | output | NUM_BANKS | Per bank: read/write is legal |
| may_pre_o | output | NUM_BANKS | Per bank: PRE is legal |
| may_ref_o | output | 1 | Rank: REF is legal |
| rank_rd_ok_o | output | 1 | Rank: write-to-read spacing has elapsed |
| err_o | output | 1 | One-cycle pulse after an illegal command |
| cfg_bad_o | output | 1 | Row-active time too short for the configuration |

## Verification
The assertions assume that `cmd_i` and `bank_i` hold known values outside reset. They also assume that each timing input is read at the edge where a command uses it, so the configuration only has to be stable at that edge. The assertions that check that a flag is blocked right after a command are guarded on spacings above 1. This keeps them correct for any programmed value. The stimulus changes the configuration only while reset is asserted or when no commands are in flight. It drives only the listed codes and bank indices below NUM_BANKS, so every assumption holds for the whole run.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;
endpackage

// File: rtl/dbt_cfg_check.sv
module dbt_cfg_check #(
  parameter int TW      = 6,
  parameter int MIN_GAP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tcl,
  input  logic [TW-1:0] trcd,
  input  logic [TW-1:0] tras,
  input  logic [TW-1:0] trtp,
  input  logic [TW-1:0] twtr,
  output logic [TW-1:0] trtp_eff,
  output logic [TW-1:0] twtr_eff,
  output logic          bad_o
);
  localparam int SW = TW + 2;
  localparam logic [TW-1:0] FLOOR = TW'(MIN_GAP);

  logic [SW-1:0] need;

  // effective spacings never go below the floor
  assign trtp_eff = (trtp < FLOOR) ? FLOOR : trtp;
  assign twtr_eff = (twtr < FLOOR) ? FLOOR : twtr;
  assign need     = SW'(tcl) + SW'(trcd) + SW'(trtp_eff);

  always_ff @(posedge clk) begin
    if (rst) bad_o <= 1'b0;
    else     bad_o <= (SW'(tras) < need);
  end
endmodule

// File: rtl/dbt_bank.sv
module dbt_bank #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_act,
  input  logic          do_rd,
  input  logic          do_wr,
  input  logic          do_pre,
  input  logic [TW-1:0] trcd,
  input  logic [TW-1:0] tras,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] trtp,
  input  logic [TW-1:0] twr,
  output logic          open_o,
  output logic          gate_zero_o,
  output logic          pre_zero_o
);
  logic          open_q, open_d;
  logic [TW-1:0] gate_q, gate_d;  // closed: tRP, open: tRCD
  logic [TW-1:0] pre_q, pre_d;    // max of tRAS, tRTP, tWR windows
  logic [TW-1:0] pre_dec;

  function automatic logic [TW-1:0] load_of(input logic [TW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [TW-1:0] dec_of(input logic [TW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [TW-1:0] max_of(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign pre_dec = dec_of(pre_q);

  always_comb begin
    open_d = open_q;
    gate_d = dec_of(gate_q);
    pre_d  = pre_dec;
    if (do_act) begin
      open_d = 1'b1;
      gate_d = load_of(trcd);
      pre_d  = load_of(tras);
    end
    if (do_pre) begin
      open_d = 1'b0;
      gate_d = load_of(trp);
    end
    if (do_rd) pre_d = max_of(pre_dec, load_of(trtp));
    if (do_wr) pre_d = max_of(pre_dec, load_of(twr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      gate_q <= '0;
      pre_q  <= '0;
    end else begin
      open_q <= open_d;
      gate_q <= gate_d;
      pre_q  <= pre_d;
    end
  end

  assign open_o      = open_q;
  assign gate_zero_o = (gate_q == '0);
  assign pre_zero_o  = (pre_q == '0);
endmodule

// File: rtl/dbt_rank_timer.sv
module dbt_rank_timer #(
  parameter int TW    = 6,
  parameter int RFC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_ref,
  input  logic             do_wr,
  input  logic [RFC_W-1:0] trfc,
  input  logic [TW-1:0]    twtr,
  output logic             rfc_zero_o,
  output logic             wtr_zero_o
);
  logic [RFC_W-1:0] rfc_q;
  logic [TW-1:0]    wtr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rfc_q <= '0;
      wtr_q <= '0;
    end else begin
      if (do_ref)             rfc_q <= (trfc == '0) ? '0 : trfc - 1'b1;
      else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;
      if (do_wr)              wtr_q <= (twtr == '0) ? '0 : twtr - 1'b1;
      else if (wtr_q != '0)   wtr_q <= wtr_q - 1'b1;
    end
  end

  assign rfc_zero_o = (rfc_q == '0);
  assign wtr_zero_o = (wtr_q == '0);
endmodule

// File: rtl/dbt_tracker.sv
module dbt_tracker #(
  parameter  int NUM_BANKS = 8,
  parameter  int TW        = 6,
  parameter  int RFC_W     = 9,
  parameter  int MIN_GAP   = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [TW-1:0]        cfg_tcl,
  input  logic [TW-1:0]        cfg_trcd,
  input  logic [TW-1:0]        cfg_tras,
  input  logic [TW-1:0]        cfg_trp,
  input  logic [TW-1:0]        cfg_trtp,
  input  logic [TW-1:0]        cfg_twr,
  input  logic [TW-1:0]        cfg_twtr,
  input  logic [RFC_W-1:0]     cfg_trfc,
  output logic [NUM_BANKS-1:0] may_act_o,
  output logic [NUM_BANKS-1:0] may_rw_o,
  output logic [NUM_BANKS-1:0] may_pre_o,
  output logic                 may_ref_o,
  output logic                 rank_rd_ok_o,
  output logic                 err_o,
  output logic                 cfg_bad_o
);
  import dbt_pkg::*;

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] sel, open_v, gate_zero, pre_zero;
  logic [NUM_BANKS-1:0] act_v, rd_v, wr_v, pre_v;
  logic [TW-1:0]        trtp_eff, twtr_eff;
  logic                 rfc_zero, wtr_zero;
  logic                 legal, is_cmd, err_q;
  logic                 do_ref, any_wr;

  assign cmd = cmd_e'(cmd_i);

  dbt_cfg_check #(.TW(TW), .MIN_GAP(MIN_GAP)) u_cfg (
    .clk(clk), .rst(rst),
    .tcl(cfg_tcl), .trcd(cfg_trcd), .tras(cfg_tras),
    .trtp(cfg_trtp), .twtr(cfg_twtr),
    .trtp_eff(trtp_eff), .twtr_eff(twtr_eff), .bad_o(cfg_bad_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b] = (bank_i == BANK_W'(b));

    dbt_bank #(.TW(TW)) u_bank (
      .clk(clk), .rst(rst),
      .do_act(act_v[b]), .do_rd(rd_v[b]), .do_wr(wr_v[b]), .do_pre(pre_v[b]),
      .trcd(cfg_trcd), .tras(cfg_tras), .trp(cfg_trp),
      .trtp(trtp_eff), .twr(cfg_twr),
      .open_o(open_v[b]), .gate_zero_o(gate_zero[b]), .pre_zero_o(pre_zero[b])
    );

    assign may_act_o[b] = ~open_v[b] & gate_zero[b] & rfc_zero;
    assign may_rw_o[b]  =  open_v[b] & gate_zero[b] & rfc_zero;
    assign may_pre_o[b] =  open_v[b] & pre_zero[b]  & rfc_zero;

    assign act_v[b] = sel[b] & legal & (cmd == CMD_ACT);
    assign rd_v[b]  = sel[b] & legal & (cmd == CMD_RD);
    assign wr_v[b]  = sel[b] & legal & (cmd == CMD_WR);
    assign pre_v[b] = sel[b] & legal & (cmd == CMD_PRE);
  end

  assign may_ref_o    = ~(|open_v) & (&gate_zero) & rfc_zero;
  assign rank_rd_ok_o = wtr_zero;

  always_comb begin
    is_cmd = 1'b1;
    unique case (cmd)
      CMD_ACT: legal = |(may_act_o & sel);
      CMD_RD:  legal = |(may_rw_o & sel) & wtr_zero;
      CMD_WR:  legal = |(may_rw_o & sel);
      CMD_PRE: legal = |(may_pre_o & sel);
      CMD_REF: legal = may_ref_o;
      default: begin
        legal  = 1'b0;
        is_cmd = 1'b0;
      end
    endcase
  end

  assign do_ref = legal & (cmd == CMD_REF);
  assign any_wr = |wr_v;

  dbt_rank_timer #(.TW(TW), .RFC_W(RFC_W)) u_rank (
    .clk(clk), .rst(rst),
    .do_ref(do_ref), .do_wr(any_wr),
    .trfc(cfg_trfc), .twtr(twtr_eff),
    .rfc_zero_o(rfc_zero), .wtr_zero_o(wtr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= is_cmd & ~legal;
  end

  assign err_o = err_q;
endmodule

// File: rtl/dbt_tracker_chk.sv
module dbt_tracker_chk #(
  parameter  int NUM_BANKS = 8,
  parameter  int TW        = 6,
  parameter  int RFC_W     = 9,
  parameter  int MIN_GAP   = 4,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [TW-1:0]        cfg_tcl,
  input logic [TW-1:0]        cfg_trcd,
  input logic [TW-1:0]        cfg_tras,
  input logic [TW-1:0]        cfg_trp,
  input logic [TW-1:0]        cfg_trtp,
  input logic [TW-1:0]        cfg_twr,
  input logic [TW-1:0]        cfg_twtr,
  input logic [RFC_W-1:0]     cfg_trfc,
  input logic [NUM_BANKS-1:0] may_act_o,
  input logic [NUM_BANKS-1:0] may_rw_o,
  input logic [NUM_BANKS-1:0] may_pre_o,
  input logic                 may_ref_o,
  input logic                 rank_rd_ok_o,
  input logic                 err_o,
  input logic                 cfg_bad_o
);
  AST_REF_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd5 && may_ref_o && cfg_trfc > 1) |=> (may_act_o == '0 && !may_ref_o)); // R6

  AST_WR_BLOCKS_RD: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd3 && |(may_rw_o & (NUM_BANKS'(1) << bank_i))) |=> !rank_rd_ok_o); // R5

  AST_REF_WITH_OPEN_ERR: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd5 && !may_ref_o) |=> err_o); // R7

  AST_NOP_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0 || cmd_i > 3'd5) |=> !err_o); // R10

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 3'd1 && bank_i == BANK_W'(b) && may_act_o[b]) |=> !may_act_o[b]); // R1

    AST_RCD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 3'd1 && bank_i == BANK_W'(b) && may_act_o[b] && cfg_trcd > 1) |=> !may_rw_o[b]); // R2

    AST_RAS_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 3'd1 && bank_i == BANK_W'(b) && may_act_o[b] && cfg_tras > 1) |=> !may_pre_o[b]); // R3

    AST_CLOSED_EXCL: assert property (@(posedge clk) disable iff (rst)
      may_act_o[b] |-> (!may_rw_o[b] && !may_pre_o[b])); // R1

    AST_RW_CLOSED_ERR: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == 3'd3 && bank_i == BANK_W'(b) && !may_rw_o[b]) |=> err_o); // R7
  end
endmodule

bind dbt_tracker dbt_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .TW(TW), .RFC_W(RFC_W), .MIN_GAP(MIN_GAP)
) u_chk (.*);

// File: tb/tb_dbt_tracker.sv
`timescale 1ns/1ps
module tb_dbt_tracker;
  localparam int NB = 8;
  localparam int TW = 6;
  localparam int RW = 9;
  localparam int NV = 29;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmd = 3'd0;
  logic [2:0]    bank = 3'd0;
  logic [TW-1:0] tcl = 6'd5, trcd = 6'd3, tras = 6'd12, trp = 6'd3;
  logic [TW-1:0] trtp = 6'd4, twr = 6'd6, twtr = 6'd4;
  logic [RW-1:0] trfc = 9'd10;
  logic [NB-1:0] may_act, may_rw, may_pre;
  logic          may_ref, rd_ok, err, cfg_bad;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbt_tracker dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank),
    .cfg_tcl(tcl), .cfg_trcd(trcd), .cfg_tras(tras), .cfg_trp(trp),
    .cfg_trtp(trtp), .cfg_twr(twr), .cfg_twtr(twtr), .cfg_trfc(trfc),
    .may_act_o(may_act), .may_rw_o(may_rw), .may_pre_o(may_pre),
    .may_ref_o(may_ref), .rank_rd_ok_o(rd_ok), .err_o(err), .cfg_bad_o(cfg_bad)
  );

  // {cmd, bank, gap to next command, expected err}
  localparam logic [11:0] VEC [NV] = '{
    {3'd1, 3'd0, 5'd2,  1'b0},  // t0  ACT b0
    {3'd2, 3'd0, 5'd1,  1'b1},  // t2  RD early (R2)
    {3'd2, 3'd0, 5'd8,  1'b0},  // t3  RD ok (R2)
    {3'd4, 3'd0, 5'd1,  1'b1},  // t11 PRE early tRAS (R3)
    {3'd4, 3'd0, 5'd2,  1'b0},  // t12 PRE ok
    {3'd1, 3'd0, 5'd1,  1'b1},  // t14 ACT early tRP (R1)
    {3'd1, 3'd0, 5'd1,  1'b0},  // t15 ACT ok
    {3'd1, 3'd0, 5'd1,  1'b1},  // t16 ACT open bank (R1)
    {3'd1, 3'd1, 5'd1,  1'b0},  // t17 ACT b1
    {3'd3, 3'd0, 5'd2,  1'b0},  // t18 WR b0
    {3'd2, 3'd1, 5'd2,  1'b1},  // t20 RD inside tWTR (R5)
    {3'd2, 3'd1, 5'd1,  1'b0},  // t22 RD ok
    {3'd5, 3'd0, 5'd1,  1'b1},  // t23 REF with open banks (R6)
    {3'd2, 3'd2, 5'd3,  1'b1},  // t24 RD closed bank (R7)
    {3'd4, 3'd0, 5'd2,  1'b0},  // t27 PRE b0
    {3'd4, 3'd1, 5'd2,  1'b0},  // t29 PRE b1
    {3'd5, 3'd1, 5'd1,  1'b1},  // t31 REF inside tRP (R6)
    {3'd5, 3'd1, 5'd9,  1'b0},  // t32 REF ok
    {3'd1, 3'd3, 5'd1,  1'b1},  // t41 ACT inside tRFC (R6)
    {3'd1, 3'd3, 5'd1,  1'b0},  // t42 ACT ok
    {3'd3, 3'd3, 5'd2,  1'b1},  // t43 WR early tRCD (R2)
    {3'd3, 3'd3, 5'd8,  1'b0},  // t45 WR ok
    {3'd3, 3'd3, 5'd5,  1'b0},  // t53 WR late
    {3'd4, 3'd3, 5'd1,  1'b1},  // t58 PRE inside tWR (R3)
    {3'd4, 3'd3, 5'd3,  1'b0},  // t59 PRE ok
    {3'd1, 3'd3, 5'd13, 1'b0},  // t62 ACT
    {3'd2, 3'd3, 5'd3,  1'b0},  // t75 RD after tRAS
    {3'd4, 3'd3, 5'd1,  1'b1},  // t78 PRE inside tRTP (R3)
    {3'd4, 3'd3, 5'd3,  1'b0}   // t79 PRE ok
  };

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [2:0] b);
    cmd  = c;
    bank = b;
    @(negedge clk);
    cmd  = 3'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9 reset state
    chk("R9 may_act", may_act, {NB{1'b1}});
    chk("R9 may_rw", may_rw, '0);
    chk("R9 may_pre", may_pre, '0);
    chk("R9 may_ref", may_ref, 1);
    chk("R9 rd_ok", rd_ok, 1);
    chk("R9 err", err, 0);
    chk("R8 good cfg", cfg_bad, 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vc, vb;
      logic [4:0] vg;
      logic       ve;
      {vc, vb, vg, ve} = VEC[i];
      issue(vc, vb);
      chk($sformatf("R7 err vec%0d", i), err, ve);
      if (vg > 1) begin
        @(negedge clk);
        chk($sformatf("R7 pulse width vec%0d", i), err, 0);
        repeat (vg - 2) @(negedge clk);
      end
    end

    // R10: unused codes act as no-ops
    issue(3'd6, 3'd0);
    chk("R10 code6 no err", err, 0);
    issue(3'd7, 3'd2);
    chk("R10 code7 no err", err, 0);
    chk("R10 bank2 still closed", may_act[2], 1);

    // R9: reset mid-operation closes banks
    issue(3'd1, 3'd2);
    chk("R1 act opens b2", may_act[2], 0);
    do_reset();
    chk("R9 after reset act", may_act, {NB{1'b1}});
    chk("R9 after reset rw", may_rw, '0);

    // R4 floors on tRTP and tWTR
    trtp = 6'd1;
    twtr = 6'd2;
    tras = 6'd4;
    do_reset();
    @(negedge clk);
    chk("R8 short tRAS flagged", cfg_bad, 1);
    issue(3'd1, 3'd5);                 // window t+1
    @(negedge clk);                    // t+2
    chk("R2 rw blocked", may_rw[5], 0);
    @(negedge clk);                    // t+3
    chk("R2 rw open", may_rw[5], 1);
    issue(3'd2, 3'd5);                 // RD at t+3
    chk("R4 rd legal", err, 0);
    repeat (2) @(negedge clk);         // t+6
    chk("R4 tRTP floor holds PRE", may_pre[5], 0);
    @(negedge clk);                    // t+7
    chk("R4 tRTP floor ends", may_pre[5], 1);
    issue(3'd3, 3'd5);                 // WR at t+7
    repeat (2) @(negedge clk);         // t+10
    chk("R4 tWTR floor holds read", rd_ok, 0);
    @(negedge clk);                    // t+11
    chk("R5 tWTR ends", rd_ok, 1);

    // R8 threshold uses the floored tRTP
    tras = 6'd12;
    @(negedge clk);
    chk("R8 boundary ok", cfg_bad, 0);
    tras = 6'd11;
    @(negedge clk);
    chk("R8 one short", cfg_bad, 1);

    finish_run();
  end
endmodule